// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block sits between a requester and a word-addressed backing memory. It turns single-bit alias accesses into ordinary accesses on that memory. A 32 MiB alias window is laid over a smaller backing region. Every 32-bit word in the alias window stands for exactly one bit of the backing region. Reading an alias word returns that one bit in bit 0. Writing an alias word copies bit 0 of the write data into that bit and leaves all other backing bits untouched.

A write is carried out as a read followed by a write on the downstream port. The bridge accepts no other upstream request until both beats and the upstream response have completed, so the two beats cannot be split by another request on this port. The access size (1, 2 or 4 bytes) sets how the backing address is aligned and how many alias words share one backing access. An error on a downstream beat is passed back to the requester. An error on the read beat also cancels the write beat. A chip normally has two instances: one with backing base 0x2000_0000 aliased at 0x2200_0000, and one with backing base 0x4000_0000 aliased at 0x4200_0000. Decoding of the window is done outside this block.

Top module: `bitalias_bridge`

## Requirements
- R1: The backing byte address is BASE OR (alias offset >> 5). The alias offset is bits [24:0] of the request address, and address bits [31:25] have no effect on the access or its result.
- R2: The backing address is rounded down to a multiple of the access size N before the downstream access. The downstream size field carries N.
- R3: Size is encoded as a byte count, and only 1, 2 and 4 are legal. Any other size code gets a single error response with read data 0 and causes no downstream beat.
- R4: The bit index is (alias offset >> 2) mod 8N. Downstream data is right-justified and little-endian: byte k of the N bytes is on data bits [8k+7:8k]. Index bits [4:3] select the byte and index bits [2:0] select the bit in that byte.
- R5: A read response carries the selected backing bit in bit 0 and zero in bits [31:1].
- R6: A write does a downstream read and then a downstream write to the same address. The write sets the selected bit when write-data bit 0 is 1 and clears it when that bit is 0. All other bits of the N bytes are unchanged. The write response carries data 0.
- R7: An error on the downstream read beat gives an upstream error response. For a write request, that error also means no downstream write beat is issued.
- R8: The upstream error status of a write request equals the error status of its downstream write beat.
- R9: After a request is accepted, s_ready stays low until its response has been given.
- R10: Each accepted request gets exactly one upstream response. The response is a single-cycle s_rvalid pulse. A downstream request is held with stable fields until m_ready.
- R11: After reset, s_ready is 1 and s_rvalid and m_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Upstream request valid |
| s_ready | output | 1 | Upstream request accepted when high with s_valid |
| s_addr | input | 32 | Alias address; bits [24:0] are used |
| s_wdata | input | 32 | Write data; bit 0 is the bit value |
| s_size | input | 3 | Access size in bytes (1, 2, 4) |
| s_we | input | 1 | 1 = write, 0 = read |
| s_rvalid | output | 1 | Upstream response pulse |
| s_rdata | output | 32 | Response data |
| s_err | output | 1 | Response error |
| m_valid | output | 1 | Downstream request valid |
| m_ready | input | 1 | Downstream request accepted |
| m_addr | output | 32 | Downstream byte address |
| m_wdata | output | 32 | Downstream write data, right-justified |
| m_size | output | 3 | Downstream size in bytes |
| m_we | output | 1 | Downstream write enable |
| m_rvalid | input | 1 | Downstream response pulse |
| m_rdata | input | 32 | Downstream read data, right-justified |
| m_err | input | 1 | Downstream response error |

## Verification
The hardest case to reach from the ports is a write whose read beat succeeds but whose write beat fails. A second hard case is a write whose read beat fails, where the absence of a write beat has to be seen rather than assumed. The bench memory model returns read errors for one backing sub-range and write-only errors for another. Directed alias offsets are computed to land in each sub-range, and counts of downstream read and write beats are compared per request. Random traffic with varying ready and response latency then mixes sizes and set/clear writes, and a final comparison of the whole model memory against the bench's reference shows that no neighbouring bit was disturbed.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;
  localparam int AW   = 32;
  localparam int DW   = 32;
  localparam int OFFW = 25;
  localparam int BPW  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT, ST_RESP
  } bb_state_e;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  // backing byte address, aligned down to the access size
  function automatic logic [AW-1:0] backing_addr(input logic [AW-1:0] base,
                                                 input logic [OFFW-1:0] off,
                                                 input logic [2:0] sz);
    logic [AW-1:0] raw;
    logic [AW-1:0] mask;
    raw  = base | (AW'(off) >> 5);
    mask = AW'(sz) - AW'(1);
    return raw & ~mask;
  endfunction

  // bit index inside the N accessed bytes
  function automatic logic [BPW-1:0] bit_index(input logic [OFFW-1:0] off,
                                               input logic [2:0] sz);
    logic [BPW-1:0] raw;
    raw = off[BPW+1:2];
    case (sz)
      3'd1:    return {2'b00, raw[2:0]};
      3'd2:    return {1'b0, raw[3:0]};
      default: return raw;
    endcase
  endfunction
endpackage

// File: rtl/bitalias_xlate.sv
module bitalias_xlate
  import bitalias_pkg::*;
#(
  parameter logic [AW-1:0] BASE = 32'h2000_0000
) (
  input  logic [OFFW-1:0] off,
  input  logic [2:0]      size,
  output logic [AW-1:0]   baddr,
  output logic [BPW-1:0]  bidx
);
  always_comb begin
    baddr = backing_addr(BASE, off, size);
    bidx  = bit_index(off, size);
  end
endmodule

// File: rtl/bitalias_lane.sv
module bitalias_lane
  import bitalias_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  rdata,
  input  logic [BPW-1:0] bidx,
  input  logic           wbit,
  output logic           bit_out,
  output logic [DW-1:0]  merged
);
  logic [DW-1:0] sel;

  always_comb begin
    sel     = DW'(1) << bidx;
    bit_out = |(rdata & sel);
    merged  = wbit ? (rdata | sel) : (rdata & ~sel);
  end

  // R6
  merge_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(merged ^ rdata) <= 1) && (merged[bidx] == wbit));
endmodule

// File: rtl/bitalias_ctrl.sv
module bitalias_ctrl
  import bitalias_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  input  logic in_ok,
  input  logic req_we,
  input  logic m_ready,
  input  logic m_rvalid,
  input  logic m_err,
  output logic s_ready,
  output logic s_rvalid,
  output logic m_valid,
  output logic m_we,
  output logic accept_evt,
  output logic rd_done_evt,
  output logic wr_done_evt
);
  bb_state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (s_valid) nxt = in_ok ? ST_RD_REQ : ST_RESP;
      ST_RD_REQ:  if (m_ready) nxt = ST_RD_WAIT;
      ST_RD_WAIT: if (m_rvalid) nxt = (m_err || !req_we) ? ST_RESP : ST_WR_REQ;
      ST_WR_REQ:  if (m_ready) nxt = ST_WR_WAIT;
      ST_WR_WAIT: if (m_rvalid) nxt = ST_RESP;
      ST_RESP:    nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign s_ready     = (state == ST_IDLE);
  assign s_rvalid    = (state == ST_RESP);
  assign m_valid     = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign m_we        = (state == ST_WR_REQ);
  assign accept_evt  = s_valid && s_ready;
  assign rd_done_evt = (state == ST_RD_WAIT) && m_rvalid;
  assign wr_done_evt = (state == ST_WR_WAIT) && m_rvalid;

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !s_ready);
  // R10
  single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |=> !s_rvalid);
  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_we)));
  // R7
  rd_err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done_evt && m_err) |=> (s_rvalid && !m_valid));
endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
  import bitalias_pkg::*;
#(
  parameter logic [31:0] BASE = 32'h2000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_addr,
  input  logic [31:0] s_wdata,
  input  logic [2:0]  s_size,
  input  logic        s_we,
  output logic        s_rvalid,
  output logic [31:0] s_rdata,
  output logic        s_err,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [31:0] m_addr,
  output logic [31:0] m_wdata,
  output logic [2:0]  m_size,
  output logic        m_we,
  input  logic        m_rvalid,
  input  logic [31:0] m_rdata,
  input  logic        m_err
);
  logic [OFFW-1:0] req_off;
  logic [2:0]      req_size;
  logic            req_we;
  logic            req_wbit;
  logic [DW-1:0]   wr_data;
  logic [DW-1:0]   resp_data;
  logic            resp_err;
  logic [BPW-1:0]  bidx;
  logic            ext_bit;
  logic [DW-1:0]   merged;
  logic            in_ok;
  logic            accept_evt, rd_done_evt, wr_done_evt;
  logic            unused_hi;

  assign in_ok     = size_legal(s_size);
  assign unused_hi = ^{s_wdata[31:1], s_addr[31:OFFW]};

  bitalias_xlate #(.BASE(BASE)) u_xlate (
    .off(req_off), .size(req_size), .baddr(m_addr), .bidx(bidx)
  );

  bitalias_lane u_lane (
    .clk(clk), .rst_n(rst_n), .rdata(m_rdata), .bidx(bidx),
    .wbit(req_wbit), .bit_out(ext_bit), .merged(merged)
  );

  bitalias_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .in_ok(in_ok),
    .req_we(req_we), .m_ready(m_ready), .m_rvalid(m_rvalid), .m_err(m_err),
    .s_ready(s_ready), .s_rvalid(s_rvalid), .m_valid(m_valid), .m_we(m_we),
    .accept_evt(accept_evt), .rd_done_evt(rd_done_evt), .wr_done_evt(wr_done_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_off   <= '0;
      req_size  <= 3'd4;
      req_we    <= 1'b0;
      req_wbit  <= 1'b0;
      wr_data   <= '0;
      resp_data <= '0;
      resp_err  <= 1'b0;
    end else begin
      if (accept_evt) begin
        req_off   <= s_addr[OFFW-1:0];
        req_size  <= s_size;
        req_we    <= s_we;
        req_wbit  <= s_wdata[0];
        resp_err  <= !in_ok;
        resp_data <= '0;
      end
      if (rd_done_evt) begin
        resp_err  <= m_err;
        resp_data <= (req_we || m_err) ? '0 : DW'(ext_bit);
        if (req_we && !m_err) wr_data <= merged;
      end
      if (wr_done_evt) begin
        resp_err  <= m_err;
        resp_data <= '0;
      end
    end
  end

  assign s_rdata = resp_data;
  assign s_err   = resp_err;
  assign m_wdata = wr_data;
  assign m_size  = req_size;

  // R5
  rd_bit0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> (s_rdata[31:1] == '0));
  // R2
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ((m_addr & (32'(m_size) - 32'd1)) == '0));
  // R1
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ((m_addr & 32'hFFF0_0000) == (BASE & 32'hFFF0_0000)));
  // R3
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !in_ok) |=> (s_rvalid && s_err && !m_valid));
  // R8
  wr_err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_evt |=> (s_rvalid && (s_err == $past(m_err))));
endmodule

// File: tb/bitalias_bridge_test.sv
module bitalias_bridge_test;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_we = 1'b0;
  logic [31:0] s_addr = '0, s_wdata = '0;
  logic [2:0]  s_size = 3'd4;
  logic        s_ready, s_rvalid, s_err;
  logic [31:0] s_rdata;
  logic        m_valid, m_we, m_ready, m_rvalid, m_err;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [2:0]  m_size;

  always #4 clk = ~clk;

  bitalias_bridge #(.BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_size(s_size), .s_we(s_we),
    .s_rvalid(s_rvalid), .s_rdata(s_rdata), .s_err(s_err),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_size(m_size), .m_we(m_we), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
    .m_err(m_err)
  );

  typedef struct { logic err; logic [31:0] data; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] addr_q[$];
  logic [2:0]  size_q[$];
  logic [7:0]  mem  [0:4095];
  logic [7:0]  refm [0:4095];
  int checks = 0, errors = 0;
  int rd_beats = 0, wr_beats = 0, resp_cnt = 0, issued = 0;

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // downstream memory model: reads fail at backing offsets 0xF00-0xFFF,
  // writes fail at 0xE00-0xEFF
  initial begin : slave
    logic [31:0] ca, cw, ea, last_a, rd;
    logic        cwe, er;
    logic [2:0]  cs, es;
    int la = 0, lb = 1;
    m_ready = 0; m_rvalid = 0; m_rdata = '0; m_err = 0;
    last_a = '0;
    forever begin
      @(negedge clk);
      if (m_valid) begin
        repeat (la) @(negedge clk);
        m_ready = 1; ca = m_addr; cw = m_wdata; cwe = m_we; cs = m_size;
        @(negedge clk);
        m_ready = 0;
        rd = '0;
        if (!cwe) begin
          rd_beats++;
          ea = (addr_q.size() != 0) ? addr_q.pop_front() : 32'hDEAD_BEEF;
          es = (size_q.size() != 0) ? size_q.pop_front() : 3'd0;
          check(ca == ea, "R1 backing address", ca, ea);
          check(cs == es, "R2 downstream size", 32'(cs), 32'(es));
          last_a = ea;
          er = (ca[11:8] == 4'hF);
          for (int k = 0; k < 4; k++)
            if (k < int'(cs)) rd[8*k +: 8] = mem[(ca[11:0] + 12'(k))];
        end else begin
          wr_beats++;
          check(ca == last_a, "R6 write beat address", ca, last_a);
          er = (ca[11:8] == 4'hE);
          if (!er)
            for (int k = 0; k < 4; k++)
              if (k < int'(cs)) mem[(ca[11:0] + 12'(k))] = cw[8*k +: 8];
        end
        repeat (lb) @(negedge clk);
        m_rvalid = 1; m_err = er; m_rdata = rd;
        @(negedge clk);
        m_rvalid = 0; m_err = 0; m_rdata = '0;
        la = (la + 1) % 3;
        lb = (lb + 2) % 3;
      end
    end
  end

  // monitor / scoreboard
  initial begin : monitor
    logic prev;
    exp_t e;
    prev = 0;
    forever begin
      @(negedge clk);
      if (s_rvalid) begin
        check(!prev, "R10 single-cycle response", 32'(prev), 32'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected response", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          check(s_err == e.err, "R3/R7/R8 error status", 32'(s_err), 32'(e.err));
          check(s_rdata == e.data, "R4/R5 response data", s_rdata, e.data);
        end
        resp_cnt++;
      end
      prev = s_rvalid;
    end
  end

  task automatic do_req(input logic we, input logic [31:0] addr,
                        input logic [2:0] sz, input logic wbit);
    logic [31:0] off, ba, al, bp, bytea;
    logic        legal, rerr, werr;
    int          n, rb0, wb0;
    exp_t        e;
    legal = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    n     = legal ? int'(sz) : 1;
    off   = addr & 32'h01FF_FFFF;
    ba    = BASE + off / 32;
    al    = ba - (ba % n);
    bp    = (off / 4) % (8 * n);
    bytea = al + bp / 8;
    rerr  = legal && (al[11:8] == 4'hF);
    werr  = legal && we && !rerr && (al[11:8] == 4'hE);
    e.err  = !legal || rerr || werr;
    e.data = '0;
    if (legal && !rerr && !we) e.data = 32'(refm[bytea[11:0]][bp % 8]);
    if (legal && we && !rerr && !werr) refm[bytea[11:0]][bp % 8] = wbit;
    exp_q.push_back(e);
    if (legal) begin addr_q.push_back(al); size_q.push_back(sz); end
    rb0 = rd_beats; wb0 = wr_beats;
    while (!s_ready) @(negedge clk);
    s_valid = 1; s_we = we; s_addr = addr; s_size = sz;
    s_wdata = {$urandom_range(0, 1) ? 31'h7FFF_FFFF : 31'h0, wbit};
    issued++;
    @(negedge clk);
    s_valid = 0;
    check(!s_ready, "R9 busy after accept", 32'(s_ready), 32'd0);
    while (resp_cnt != issued) @(negedge clk);
    check((rd_beats - rb0) == (legal ? 1 : 0), "R3 read beats",
          32'(rd_beats - rb0), legal ? 32'd1 : 32'd0);
    check((wr_beats - wb0) == ((legal && we && !rerr) ? 1 : 0), "R7 write beats",
          32'(wr_beats - wb0), (legal && we && !rerr) ? 32'd1 : 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] lf;
    for (int i = 0; i < 4096; i++) begin
      mem[i]  = 8'(i * 37 + 5);
      refm[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    check(s_ready == 1, "R11 s_ready", 32'(s_ready), 32'd1);
    check(s_rvalid == 0, "R11 s_rvalid", 32'(s_rvalid), 32'd0);
    check(m_valid == 0, "R11 m_valid", 32'(m_valid), 32'd0);
    rst_n = 1;
    @(negedge clk);
    // R5 R4 reads at each size
    do_req(0, 32'h2200_0000, 3'd4, 0);
    do_req(0, 32'h2200_0000 + 32'h7C, 3'd4, 0);
    do_req(0, 32'h2200_0000 + 32'h1234, 3'd2, 0);
    do_req(0, 32'h2200_0000 + 32'h2468, 3'd1, 0);
    // R1 upper address bits ignored
    do_req(0, 32'hFE00_0000 | 32'h1234, 3'd2, 0);
    do_req(0, 32'h5A00_0000 | 32'h0123_4564, 3'd4, 0);
    // R6 set / clear then read back, and neighbours
    do_req(1, 32'h2200_0040, 3'd4, 1);
    do_req(0, 32'h2200_0040, 3'd4, 0);
    do_req(0, 32'h2200_0044, 3'd4, 0);
    do_req(1, 32'h2200_0040, 3'd1, 0);
    do_req(0, 32'h2200_0040, 3'd2, 0);
    do_req(1, 32'h2200_00FC, 3'd2, 1);
    do_req(0, 32'h2200_00FC, 3'd1, 0);
    // R3 illegal sizes
    do_req(0, 32'h2200_0010, 3'd0, 0);
    do_req(1, 32'h2200_0010, 3'd3, 1);
    do_req(0, 32'h2200_0010, 3'd5, 0);
    do_req(1, 32'h2200_0010, 3'd7, 1);
    // R7 read-beat error: read and write
    do_req(0, 32'h2201_E200, 3'd4, 0);
    do_req(1, 32'h2201_E204, 3'd2, 1);
    // R8 write-beat error, memory unchanged afterwards
    do_req(1, 32'h2201_C400, 3'd4, 1);
    do_req(1, 32'h2201_C404, 3'd4, 0);
    do_req(0, 32'h2201_C400, 3'd4, 0);
    // random traffic
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      do_req(lf[20], 32'h2200_0000 + (lf % 32'h1C000),
             (lf[23:22] == 2'd0) ? 3'd1 : (lf[23:22] == 2'd1) ? 3'd2 : 3'd4,
             lf[9]);
    end
    // R6 no stray bit changes anywhere
    begin
      int bad = 0;
      for (int i = 0; i < 4096; i++) if (mem[i] != refm[i]) bad++;
      check(bad == 0, "R6 memory image", 32'(bad), 32'd0);
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 responses outstanding", 32'(exp_q.size()), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule